// File: doc/BRIEF.md
# Interrupt-Mask and Mode Change Unit

This block decodes one processor-state-change instruction and applies it to a small architectural state register. The register holds three interrupt mask bits (asynchronous abort, normal interrupt, fast interrupt), a 5-bit processor mode and a sticky illegal-state flag. The instruction can arrive in one of three encodings: a 32-bit fixed-width word, a 16-bit compact halfword, or a 32-bit compact pair of halfwords. A format tag selects the encoding. Two qualifier inputs come with each instruction: one says whether it sits inside a conditional block, and one says whether the core currently runs at user privilege.

A valid instruction either sets or clears each selected mask bit, and it can also write a new mode. Mode legality comes from a 32-bit lookup input indexed by the requested mode. When the requested mode is not legal, the old mode is kept and the illegal-state flag is raised. Every reserved bit combination resolves to one fixed outcome. The combination imod=01 is reported as undefined. Every other reserved case is reported as a NOP with no state effect. An all-zero imod/M pair in the 32-bit compact encoding belongs to the hint space, and the block signals that escape instead of executing the instruction.

Top module: `cps_unit`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) sets all three mask bits to 1, loads the mode with parameter RESET_MODE and clears the illegal flag.
- R2: For an executed instruction, imod=10 clears each mask bit whose select bit is 1 and imod=11 sets it. Unselected mask bits keep their value. Select bits are A/I/F at instr_i[8:6] (fmt_i=00, fixed word: bits 31:20 = 0xF10, imod 19:18, M 17, mode 4:0) and at instr_i[7:5] (fmt_i=10, compact pair: high halfword 0xF3A then 1111; low halfword bits 15:11 = 10000, imod 10:9, M 9th bit 8, mode 4:0).
- R3: With fmt_i=01, only instr_i[15:0] is decoded: bits 15:5 = 10110110011, bit 4 = im (0 clears, 1 sets), bit 3 reserved zero, A/I/F at bits 2:0. The mode is never changed. A:I:F=000 gives a NOP.
- R4: With M=1 and legal_mask_i[mode]=1, an executed instruction writes the mode field at the next edge and leaves the illegal flag unchanged.
- R5: With M=1 and legal_mask_i[mode]=0, the mode is kept and the illegal flag is set. The mask update still takes effect.
- R6: imod=01 in either 32-bit encoding raises undef_o and changes no state.
- R7: With fmt_i=10, imod=00 and M=0 raise hint_o and change no state.
- R8: Each of the following raises nop_o and changes no state:
  - imod=00 with M=0 in the fixed word;
  - A:I:F=000 with imod bit 1 set;
  - A:I:F nonzero with imod bit 1 clear;
  - a nonzero mode field with M=0;
  - a compact encoding with in_cond_i=1;
  - a reserved bit at the wrong value (fixed word bits 15:9 not zero; compact pair high bits 3:0 not 1111, or low bits 13/11 not zero).
- R9: With user_i=1, an instruction that would otherwise execute raises nop_o and changes no state.
- R10: A mismatch in any fixed opcode bit, or fmt_i=11, raises undef_o and changes no state.
- R11: While valid_i is low, undef_o, nop_o and hint_o are 0 and the state holds.
- R12: At most one of undef_o, nop_o and hint_o is high in any cycle. The outcome outputs respond combinationally to the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction present this cycle |
| fmt_i | input | 2 | Encoding tag: 00 fixed, 01 16-bit compact, 10 32-bit compact |
| instr_i | input | 32 | Instruction bits; 32-bit compact holds first halfword in 31:16 |
| in_cond_i | input | 1 | Instruction lies inside a conditional block |
| user_i | input | 1 | Current privilege is user |
| legal_mask_i | input | 32 | Bit n high when mode n may be written |
| mask_a_o | output | 1 | Asynchronous-abort mask |
| mask_i_o | output | 1 | Normal-interrupt mask |
| mask_f_o | output | 1 | Fast-interrupt mask |
| mode_o | output | 5 | Current mode |
| illegal_o | output | 1 | Illegal-state flag |
| undef_o | output | 1 | Instruction is undefined |
| nop_o | output | 1 | Instruction retired as NOP |
| hint_o | output | 1 | Encoding escapes to the hint space |

## Verification
The bench overrides RESET_MODE to 5'h1A, so that R1 observes a value that differs from the default. With that value, the first mode write in the sweep is always a visible change. The legal-mode lookup is driven with 32'h888F_0000, which makes modes 0x10–0x13, 0x17, 0x1B and 0x1F legal. The sweep alternates between legal mode 0x10 and illegal mode 0x06, so both the write path and the illegal-flag path are reached in every 32-bit encoding.

// File: rtl/cps_pkg.sv
package cps_pkg;
    localparam int MODE_W = 5;
    localparam int NMODES = 1 << MODE_W;

    typedef enum logic [1:0] {
        FMT_W32 = 2'b00,
        FMT_N16 = 2'b01,
        FMT_N32 = 2'b10,
        FMT_BAD = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        OUT_EXEC  = 2'b00,
        OUT_NOP   = 2'b01,
        OUT_UNDEF = 2'b10,
        OUT_HINT  = 2'b11
    } outcome_e;

    // Encoding-independent view of one instruction
    typedef struct packed {
        logic              op_ok;     // fixed opcode bits match
        logic              rsv_ok;    // should-be bits hold their value
        logic              compact;   // either compact encoding
        logic              pair;      // 32-bit compact encoding
        logic [1:0]        imod;
        logic              chg;       // M bit
        logic [2:0]        sel;       // A:I:F select
        logic [MODE_W-1:0] mode;
    } fields_t;

    typedef struct packed {
        logic              a;
        logic              i;
        logic              f;
        logic [MODE_W-1:0] mode;
        logic              il;
    } pstate_t;

    // Set or clear the selected mask bits, keep the rest
    function automatic logic [2:0] mask_update(logic [2:0] cur, logic [2:0] sel, logic set);
        return set ? (cur | sel) : (cur & ~sel);
    endfunction
endpackage

// File: rtl/cps_fields.sv
module cps_fields
    import cps_pkg::*;
(
    input  logic [1:0]  fmt_i,
    input  logic [31:0] instr_i,
    output fields_t     fld_o
);
    localparam logic [11:0] W32_OP = 12'hF10;
    localparam logic [10:0] N16_OP = 11'b10110110011;
    localparam logic [11:0] N32_OP = 12'hF3A;

    always_comb begin
        fld_o = '0;
        unique case (fmt_e'(fmt_i))
            FMT_W32: begin
                fld_o.op_ok  = (instr_i[31:20] == W32_OP) && !instr_i[16] && !instr_i[5];
                fld_o.rsv_ok = (instr_i[15:9] == 7'd0);
                fld_o.imod   = instr_i[19:18];
                fld_o.chg    = instr_i[17];
                fld_o.sel    = instr_i[8:6];
                fld_o.mode   = instr_i[MODE_W-1:0];
            end
            FMT_N16: begin
                fld_o.op_ok   = (instr_i[15:5] == N16_OP);
                fld_o.rsv_ok  = !instr_i[3];
                fld_o.compact = 1'b1;
                fld_o.imod    = {1'b1, instr_i[4]};
                fld_o.sel     = instr_i[2:0];
            end
            FMT_N32: begin
                fld_o.op_ok   = (instr_i[31:20] == N32_OP) && (instr_i[15:14] == 2'b10)
                                && !instr_i[12];
                fld_o.rsv_ok  = (instr_i[19:16] == 4'hF) && !instr_i[13] && !instr_i[11];
                fld_o.compact = 1'b1;
                fld_o.pair    = 1'b1;
                fld_o.imod    = instr_i[10:9];
                fld_o.chg     = instr_i[8];
                fld_o.sel     = instr_i[7:5];
                fld_o.mode    = instr_i[MODE_W-1:0];
            end
            default: fld_o = '0;
        endcase
    end
endmodule

// File: rtl/cps_classify.sv
module cps_classify
    import cps_pkg::*;
(
    input  fields_t  fld_i,
    input  logic     in_cond_i,
    input  logic     user_i,
    output outcome_e kind_o
);
    logic reserved;

    always_comb begin
        reserved = !fld_i.rsv_ok
                 || (fld_i.compact && in_cond_i)
                 || (fld_i.imod == 2'b00 && !fld_i.chg)
                 || (fld_i.imod[1] && fld_i.sel == 3'b000)
                 || (!fld_i.imod[1] && fld_i.sel != 3'b000)
                 || (!fld_i.chg && fld_i.mode != '0);

        if (!fld_i.op_ok)                                       kind_o = OUT_UNDEF;
        else if (fld_i.pair && fld_i.imod == 2'b00 && !fld_i.chg) kind_o = OUT_HINT;
        else if (fld_i.imod == 2'b01)                           kind_o = OUT_UNDEF;
        else if (reserved || user_i)                            kind_o = OUT_NOP;
        else                                                    kind_o = OUT_EXEC;
    end
endmodule

// File: rtl/cps_state.sv
module cps_state
    import cps_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = 5'h13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  fields_t           fld_i,
    input  logic [NMODES-1:0] legal_mask_i,
    output pstate_t           st_o
);
    pstate_t st_q;
    logic    legal;
    logic [2:0] nxt_mask;

    assign legal    = legal_mask_i[fld_i.mode];
    assign nxt_mask = mask_update({st_q.a, st_q.i, st_q.f}, fld_i.sel, fld_i.imod[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.a    <= 1'b1;
            st_q.i    <= 1'b1;
            st_q.f    <= 1'b1;
            st_q.mode <= RESET_MODE;
            st_q.il   <= 1'b0;
        end else if (upd_i) begin
            if (fld_i.imod[1]) {st_q.a, st_q.i, st_q.f} <= nxt_mask;
            if (fld_i.chg) begin
                if (legal) st_q.mode <= fld_i.mode;
                else       st_q.il   <= 1'b1;
            end
        end
    end

    assign st_o = st_q;

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (st_q.a && st_q.i && st_q.f && st_q.mode == RESET_MODE && !st_q.il));

    // R4: legal mode write lands
    p_legal_mode_r4: assert property (@(posedge clk) disable iff (rst)
        upd_i && fld_i.chg && legal |=> st_q.mode == $past(fld_i.mode));

    p_illegal_mode_r5: assert property (@(posedge clk) disable iff (rst)
        upd_i && fld_i.chg && !legal |=> st_q.il && $stable(st_q.mode));
endmodule

// File: rtl/cps_unit.sv
// Fixed resolution of reserved encodings: imod=01 and any opcode mismatch
// report undefined; every other reserved combination retires as a NOP with
// no state effect and undef_o low.
module cps_unit
    import cps_pkg::*;
#(
    parameter logic [4:0] RESET_MODE = 5'h13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [1:0]  fmt_i,
    input  logic [31:0] instr_i,
    input  logic        in_cond_i,
    input  logic        user_i,
    input  logic [31:0] legal_mask_i,
    output logic        mask_a_o,
    output logic        mask_i_o,
    output logic        mask_f_o,
    output logic [4:0]  mode_o,
    output logic        illegal_o,
    output logic        undef_o,
    output logic        nop_o,
    output logic        hint_o
);
    fields_t  fld;
    outcome_e kind;
    pstate_t  st;
    logic     upd;

    cps_fields u_fields (
        .fmt_i   (fmt_i),
        .instr_i (instr_i),
        .fld_o   (fld)
    );

    cps_classify u_classify (
        .fld_i     (fld),
        .in_cond_i (in_cond_i),
        .user_i    (user_i),
        .kind_o    (kind)
    );

    assign upd = valid_i && (kind == OUT_EXEC);

    cps_state #(.RESET_MODE(RESET_MODE)) u_state (
        .clk          (clk),
        .rst          (rst),
        .upd_i        (upd),
        .fld_i        (fld),
        .legal_mask_i (legal_mask_i),
        .st_o         (st)
    );

    assign mask_a_o  = st.a;
    assign mask_i_o  = st.i;
    assign mask_f_o  = st.f;
    assign mode_o    = st.mode;
    assign illegal_o = st.il;
    assign undef_o   = valid_i && (kind == OUT_UNDEF);
    assign nop_o     = valid_i && (kind == OUT_NOP);
    assign hint_o    = valid_i && (kind == OUT_HINT);

    p_one_outcome_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({undef_o, nop_o, hint_o}));

    p_undef_hold_r6: assert property (@(posedge clk) disable iff (rst)
        undef_o |=> $stable(st));

    p_hint_hold_r7: assert property (@(posedge clk) disable iff (rst)
        hint_o |=> $stable(st));

    p_nop_hold_r8: assert property (@(posedge clk) disable iff (rst)
        nop_o |=> $stable(st));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(st));

    // R2: a selected A bit follows imod bit 0 after an executed change
    p_mask_a_r2: assert property (@(posedge clk) disable iff (rst)
        upd && fld.imod[1] && fld.sel[2] |=> mask_a_o == $past(fld.imod[0]));
endmodule

// File: tb/cps_unit_tb.sv
module cps_unit_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [4:0]  RST_MODE   = 5'h1A;
    localparam logic [31:0] LEGAL      = 32'h888F_0000;
    localparam int          NVEC       = 14;
    // {fmt[1:0], cond, user, instr[31:0], expected kind[1:0]}; kind 0 exec 1 nop 2 undef 3 hint
    localparam logic [37:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 1'b0, 32'hF10C01C0, 2'd0},  // R2 set all masks
        {2'd1, 1'b0, 1'b0, 32'h0000B662, 2'd0},  // R3 clear I
        {2'd2, 1'b0, 1'b0, 32'hF3AF8000, 2'd3},  // R7 hint escape
        {2'd0, 1'b0, 1'b0, 32'hF10401C0, 2'd2},  // R6 imod=01
        {2'd0, 1'b0, 1'b0, 32'hF11C01C0, 2'd2},  // R10 opcode mismatch
        {2'd1, 1'b1, 1'b0, 32'h0000B677, 2'd1},  // R8 compact in cond block
        {2'd0, 1'b1, 1'b0, 32'hF1080040, 2'd0},  // R2 fixed word ignores cond
        {2'd0, 1'b0, 1'b1, 32'hF10C01C0, 2'd1},  // R9 user level
        {2'd0, 1'b0, 1'b0, 32'hF10C03C0, 2'd1},  // R8 reserved bit 9
        {2'd2, 1'b0, 1'b0, 32'hF3AF8645, 2'd1},  // R8 mode nonzero, M=0
        {2'd3, 1'b0, 1'b0, 32'hF10C01C0, 2'd2},  // R10 bad format tag
        {2'd2, 1'b0, 1'b0, 32'hF3AF8590, 2'd0},  // R4 legal mode 0x10
        {2'd2, 1'b0, 1'b0, 32'hF3A08590, 2'd1},  // R8 reserved high bits
        {2'd2, 1'b0, 1'b0, 32'hF3AFC590, 2'd2}   // R10 fixed bit 14 wrong
    };

    logic        clk = 1'b0;
    logic        rst, valid_i, in_cond_i, user_i;
    logic [1:0]  fmt_i;
    logic [31:0] instr_i;
    logic        mask_a_o, mask_i_o, mask_f_o, illegal_o, undef_o, nop_o, hint_o;
    logic [4:0]  mode_o;

    int checks = 0;
    int fails  = 0;
    logic [8:0] model;  // {a,i,f,mode,il}

    always #(CLK_PERIOD/2) clk = ~clk;

    cps_unit #(.RESET_MODE(RST_MODE)) u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .fmt_i(fmt_i), .instr_i(instr_i),
        .in_cond_i(in_cond_i), .user_i(user_i), .legal_mask_i(LEGAL),
        .mask_a_o(mask_a_o), .mask_i_o(mask_i_o), .mask_f_o(mask_f_o), .mode_o(mode_o),
        .illegal_o(illegal_o), .undef_o(undef_o), .nop_o(nop_o), .hint_o(hint_o)
    );

    function automatic logic [1:0] ref_kind(logic [1:0] fm, logic [31:0] w, logic cnd, logic usr);
        logic shape, rsv_ok, cmp, pair, m;
        logic [1:0] im;
        logic [2:0] s;
        logic [4:0] md;
        shape = 0; rsv_ok = 1; cmp = 0; pair = 0; m = 0; im = 0; s = 0; md = 0;
        if (fm == 2'd0) begin
            shape = w[31:20] == 12'hF10 && w[16] == 0 && w[5] == 0;
            rsv_ok = w[15:9] == 0; im = w[19:18]; m = w[17]; s = w[8:6]; md = w[4:0];
        end else if (fm == 2'd1) begin
            shape = w[15:5] == 11'h5B3; rsv_ok = w[3] == 0; cmp = 1;
            im = {1'b1, w[4]}; s = w[2:0];
        end else if (fm == 2'd2) begin
            shape = w[31:20] == 12'hF3A && w[15:14] == 2'b10 && w[12] == 0;
            rsv_ok = w[19:16] == 4'hF && w[13] == 0 && w[11] == 0;
            cmp = 1; pair = 1; im = w[10:9]; m = w[8]; s = w[7:5]; md = w[4:0];
        end
        if (!shape) return 2'd2;
        if (pair && im == 0 && !m) return 2'd3;
        if (im == 2'b01) return 2'd2;
        if (!rsv_ok || (cmp && cnd)) return 2'd1;
        if (im == 0 && !m) return 2'd1;
        if (im[1] && s == 0) return 2'd1;
        if (!im[1] && s != 0) return 2'd1;
        if (!m && md != 0) return 2'd1;
        if (usr) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [8:0] ref_next(logic [8:0] cur, logic [1:0] fm, logic [31:0] w);
        logic [8:0] n;
        logic [1:0] im;
        logic [2:0] s;
        logic m;
        logic [4:0] md;
        n = cur;
        if (fm == 2'd0)      begin im = w[19:18]; m = w[17]; s = w[8:6]; md = w[4:0]; end
        else if (fm == 2'd1) begin im = {1'b1, w[4]}; m = 0; s = w[2:0]; md = 0; end
        else                 begin im = w[10:9]; m = w[8]; s = w[7:5]; md = w[4:0]; end
        for (int b = 0; b < 3; b++)
            if (s[b] && im[1]) n[6 + b] = im[0];
        if (m) begin
            if (LEGAL[md]) n[5:1] = md;
            else           n[0] = 1'b1;
        end
        return n;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] dut_state();
        return {mask_a_o, mask_i_o, mask_f_o, mode_o, illegal_o};
    endfunction

    task automatic run(string req, logic [1:0] fm, logic [31:0] w, logic cnd, logic usr,
                       logic [1:0] kind);
        @(negedge clk);
        valid_i = 1; fmt_i = fm; instr_i = w; in_cond_i = cnd; user_i = usr;
        #1;
        check(req, {29'd0, undef_o, nop_o, hint_o},
              {29'd0, kind == 2'd2, kind == 2'd1, kind == 2'd3});
        if (kind == 2'd0) model = ref_next(model, fm, w);
        @(negedge clk);
        valid_i = 0;
        check(req, {23'd0, dut_state()}, {23'd0, model});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; valid_i = 0;
        @(negedge clk);
        rst = 0;
        model = {3'b111, RST_MODE, 1'b0};
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1; valid_i = 0; fmt_i = 0; instr_i = 0; in_cond_i = 0; user_i = 0;
        model = '0;
        do_reset();
        check("R1 reset state", {23'd0, dut_state()}, {23'd0, 3'b111, RST_MODE, 1'b0});

        // R11: idle cycle with a would-execute word, outcomes low, state held
        @(negedge clk);
        fmt_i = 2'd0; instr_i = 32'hF1080040; valid_i = 0;
        #1;
        check("R11 idle outcomes", {29'd0, undef_o, nop_o, hint_o}, 32'd0);
        @(negedge clk);
        check("R11 idle state", {23'd0, dut_state()}, {23'd0, model});

        for (int k = 0; k < NVEC; k++)
            run("R12 table", VEC[k][37:36], VEC[k][33:2], VEC[k][35], VEC[k][34], VEC[k][1:0]);

        // R5: illegal mode 0x06 with clear of F: mask applies, mode kept, flag set
        do_reset();
        run("R5 illegal mode", 2'd0, 32'hF10A0046, 1'b0, 1'b0, 2'd0);
        check("R5 flag and mode", {23'd0, dut_state()}, {23'd0, 3'b110, RST_MODE, 1'b1});
        do_reset();
        check("R1 reset restores", {23'd0, dut_state()}, {23'd0, 3'b111, RST_MODE, 1'b0});

        // Sweep: every format, imod, M and A:I:F with cond/user variants (R2 R3 R6 R7 R8 R9)
        for (int f = 0; f < 3; f++)
            for (int q = 0; q < 4; q++)
                for (int im = 0; im < 4; im++)
                    for (int m = 0; m < 2; m++)
                        for (int s = 0; s < 8; s++) begin
                            logic [31:0] w;
                            logic [4:0]  md;
                            md = (m == 0) ? 5'd0 : (s[0] ? 5'h10 : 5'h06);
                            if (f == 0)
                                w = {12'hF10, im[1:0], m[0], 1'b0, 7'd0, s[2:0], 1'b0, md};
                            else if (f == 1)
                                w = {16'd0, 11'b10110110011, im[0], 1'b0, s[2:0]};
                            else
                                w = {12'hF3A, 4'hF, 5'b10000, im[1:0], m[0], s[2:0], md};
                            run("R2 R3 R6 R7 R8 R9 sweep", f[1:0], w, q[0], q[1],
                                ref_kind(f[1:0], w, q[0], q[1]));
                        end
        summary();
    end
endmodule